// File: doc/BRIEF.md
# Lowest-Priority Interrupt Redirection Unit

This block sits between the system interconnect and four processors and decides which processor receives each interrupt message. It holds one programmable task-priority register per processor. Software running on a processor rewrites its own register through an update special cycle, which the bus decoder presents as a destination ID and an 8-bit priority value. Every register starts disabled after reset and is enabled only by its own update.

An interrupt message carries a 16-bit target field, an 8-bit vector and a redirectable hint. I/O interrupts and inter-processor interrupts use the same format. When the hint is clear, the message goes to the processor named by the low bits of the target field. When the hint is set, the block picks the enabled processor with the numerically lowest priority value. A tie goes to the lowest processor index. If no register is enabled, the message goes to the addressed processor.

The decision is registered. It appears on the output one cycle after the request, together with the vector and a single-cycle valid strobe. A small two-state machine drives the strobe. `ST_IDLE` moves to `ST_SEND` when a request is sampled, and otherwise stays in `ST_IDLE`. `ST_SEND` stays in `ST_SEND` when another request is sampled, and otherwise returns to `ST_IDLE`. The strobe is high exactly while the machine is in `ST_SEND`.

Top module: `lpr_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and every priority register is disabled, so a redirectable interrupt goes to the processor given by `irq_target[1:0]`.
- R2: An update with `upd_valid` high writes `upd_prio` into the register selected by `upd_dest_id[2:0]` when that selector is 0 to 3, and enables that register. Bits 7:3 of `upd_dest_id` have no effect.
- R3: An update whose selector `upd_dest_id[2:0]` is 4 to 7 changes no register and no enable, as seen in later routing decisions.
- R4: An interrupt with `irq_redir` = 0 goes to processor `irq_target[1:0]`, whatever the register contents. Bits 15:2 of the target are ignored.
- R5: An interrupt with `irq_redir` = 1 goes to the enabled processor whose 8-bit priority value is lowest, the values compared as unsigned.
- R6: When several enabled processors share the lowest value, the one with the lowest index wins.
- R7: Disabled registers never win. A redirectable interrupt that arrives while no register is enabled goes to processor `irq_target[1:0]`.
- R8: For a request sampled at a clock edge, `out_valid` is 1 for the following cycle only, unless another request is sampled at the next edge. In that cycle `out_vector` equals the request's vector and `out_cpu` holds the decision. Back-to-back requests give back-to-back strobes.
- R9: When an update and an interrupt arrive in the same cycle, the interrupt is arbitrated against the register contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Update special cycle present |
| upd_dest_id | input | 8 | Destination ID of the update; bits 2:0 select the register |
| upd_prio | input | 8 | New priority value |
| irq_valid | input | 1 | Interrupt message present |
| irq_target | input | 16 | Target field of the message address |
| irq_redir | input | 1 | Redirectable hint |
| irq_vector | input | 8 | Interrupt vector from the data field |
| out_valid | output | 1 | Single-cycle delivery strobe |
| out_cpu | output | 2 | Selected processor index |
| out_vector | output | 8 | Delivered vector |

## Verification
The bench builds the block with its default parameters: four processors, 8-bit priorities and a 3-bit register selector. This small configuration lets the bench try every enable mask and, for each mask, all 256 combinations of priority values drawn from 0 to 3. That covers every tie pattern and every case in which a disabled register would have won. It also tries all eight selector values, including the four that must be ignored. The cases for back-to-back strobes and for an update in the same cycle as an interrupt are driven on purpose.

// File: rtl/lpr_pkg.sv
package lpr_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } route_state_e;
endpackage

// File: rtl/lpr_prio_bank.sv
module lpr_prio_bank #(
    parameter int NUM_CPU = 4,
    parameter int PRIO_W  = 8,
    parameter int SEL_W   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      upd_valid,
    input  logic [SEL_W-1:0]          upd_sel,
    input  logic [PRIO_W-1:0]         upd_prio,
    output logic [NUM_CPU*PRIO_W-1:0] prio_flat,
    output logic [NUM_CPU-1:0]        en_vec
);
    // Only selectors below NUM_CPU have a register; the rest match nothing.
    for (genvar g = 0; g < NUM_CPU; g++) begin : g_reg
        logic [PRIO_W-1:0] prio_q;
        logic              en_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_q <= '0;
                en_q   <= 1'b0;
            end else if (upd_valid && (upd_sel == SEL_W'(g))) begin
                prio_q <= upd_prio;
                en_q   <= 1'b1;
            end
        end

        assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q;
        assign en_vec[g]                     = en_q;
    end
endmodule

// File: rtl/lpr_arbiter.sv
module lpr_arbiter #(
    parameter int NUM_CPU = 4,
    parameter int PRIO_W  = 8,
    localparam int IDX_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic [NUM_CPU*PRIO_W-1:0] prio_flat,
    input  logic [NUM_CPU-1:0]        en_vec,
    output logic                      any_en,
    output logic [IDX_W-1:0]          win_idx
);
    logic [PRIO_W-1:0] best_prio;

    // Scan upward with a strict compare so the lowest index keeps a tie.
    always_comb begin
        any_en    = 1'b0;
        win_idx   = '0;
        best_prio = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (en_vec[i] &&
                (!any_en || (prio_flat[i*PRIO_W +: PRIO_W] < best_prio))) begin
                any_en    = 1'b1;
                win_idx   = IDX_W'(i);
                best_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/lpr_route_fsm.sv
module lpr_route_fsm
    import lpr_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_valid,
    input  logic [IDX_W-1:0] next_cpu,
    input  logic [VEC_W-1:0] irq_vector,
    output logic             out_valid,
    output logic [IDX_W-1:0] out_cpu,
    output logic [VEC_W-1:0] out_vector
);
    route_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = irq_valid ? ST_SEND : ST_IDLE;
            ST_SEND: state_d = irq_valid ? ST_SEND : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_cpu    <= '0;
            out_vector <= '0;
        end else if (irq_valid) begin
            out_cpu    <= next_cpu;
            out_vector <= irq_vector;
        end
    end

    assign out_valid = (state_q == ST_SEND);
endmodule

// File: rtl/lpr_unit.sv
module lpr_unit #(
    parameter int NUM_CPU = 4,
    parameter int PRIO_W  = 8,
    parameter int SEL_W   = 3,
    parameter int DID_W   = 8,
    parameter int TGT_W   = 16,
    parameter int VEC_W   = 8,
    localparam int IDX_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic [DID_W-1:0]  upd_dest_id,
    input  logic [PRIO_W-1:0] upd_prio,
    input  logic              irq_valid,
    input  logic [TGT_W-1:0]  irq_target,
    input  logic              irq_redir,
    input  logic [VEC_W-1:0]  irq_vector,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_cpu,
    output logic [VEC_W-1:0]  out_vector
);
    logic [SEL_W-1:0]          upd_sel;
    logic [IDX_W-1:0]          direct_cpu;
    logic [NUM_CPU*PRIO_W-1:0] prio_flat;
    logic [NUM_CPU-1:0]        en_vec;
    logic                      any_en;
    logic [IDX_W-1:0]          win_idx;
    logic [IDX_W-1:0]          next_cpu;
    logic                      unused_did_hi;
    logic                      unused_tgt_hi;

    assign upd_sel       = upd_dest_id[SEL_W-1:0];
    assign direct_cpu    = irq_target[IDX_W-1:0];
    assign unused_did_hi = ^upd_dest_id[DID_W-1:SEL_W];
    assign unused_tgt_hi = ^irq_target[TGT_W-1:IDX_W];

    lpr_prio_bank #(
        .NUM_CPU (NUM_CPU),
        .PRIO_W  (PRIO_W),
        .SEL_W   (SEL_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (upd_valid),
        .upd_sel   (upd_sel),
        .upd_prio  (upd_prio),
        .prio_flat (prio_flat),
        .en_vec    (en_vec)
    );

    lpr_arbiter #(
        .NUM_CPU (NUM_CPU),
        .PRIO_W  (PRIO_W)
    ) u_arb (
        .prio_flat (prio_flat),
        .en_vec    (en_vec),
        .any_en    (any_en),
        .win_idx   (win_idx)
    );

    assign next_cpu = (irq_redir && any_en) ? win_idx : direct_cpu;

    lpr_route_fsm #(
        .IDX_W (IDX_W),
        .VEC_W (VEC_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_valid  (irq_valid),
        .next_cpu   (next_cpu),
        .irq_vector (irq_vector),
        .out_valid  (out_valid),
        .out_cpu    (out_cpu),
        .out_vector (out_vector)
    );
endmodule

// File: rtl/lpr_unit_chk.sv
module lpr_unit_chk #(
    parameter int NUM_CPU = 4,
    parameter int SEL_W   = 3,
    parameter int VEC_W   = 8,
    parameter int IDX_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               upd_valid,
    input logic [SEL_W-1:0]   upd_sel,
    input logic               irq_valid,
    input logic               irq_redir,
    input logic [IDX_W-1:0]   direct_cpu,
    input logic [VEC_W-1:0]   irq_vector,
    input logic [NUM_CPU-1:0] en_vec,
    input logic               out_valid,
    input logic [IDX_W-1:0]   out_cpu,
    input logic [VEC_W-1:0]   out_vector
);
    assert_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> out_valid);

    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |=> !out_valid);

    assert_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> (out_vector == $past(irq_vector)));

    assert_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !irq_redir) |=> (out_cpu == $past(direct_cpu)));

    assert_none_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_redir && (en_vec == '0)) |=> (out_cpu == $past(direct_cpu)));

    assert_winner_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_redir && (en_vec != '0)) |=>
            (|(($past(en_vec) >> out_cpu) & NUM_CPU'(1))));

    assert_update_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (upd_sel < SEL_W'(NUM_CPU))) |=>
            (|((en_vec >> $past(upd_sel)) & NUM_CPU'(1))));

    assert_ignored_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (upd_sel >= SEL_W'(NUM_CPU))) |=> $stable(en_vec));
endmodule

bind lpr_unit lpr_unit_chk #(
    .NUM_CPU (NUM_CPU),
    .SEL_W   (SEL_W),
    .VEC_W   (VEC_W),
    .IDX_W   (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_valid  (upd_valid),
    .upd_sel    (upd_sel),
    .irq_valid  (irq_valid),
    .irq_redir  (irq_redir),
    .direct_cpu (direct_cpu),
    .irq_vector (irq_vector),
    .en_vec     (en_vec),
    .out_valid  (out_valid),
    .out_cpu    (out_cpu),
    .out_vector (out_vector)
);

// File: tb/lpr_unit_bench.sv
module lpr_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_valid = 1'b0;
    logic [7:0]  upd_dest_id = '0;
    logic [7:0]  upd_prio = '0;
    logic        irq_valid = 1'b0;
    logic [15:0] irq_target = '0;
    logic        irq_redir = 1'b0;
    logic [7:0]  irq_vector = '0;
    logic        out_valid;
    logic [1:0]  out_cpu;
    logic [7:0]  out_vector;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int m_prio [4];
    bit m_en   [4];

    always #4 clk = ~clk;

    lpr_unit u_lpr_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_valid   (upd_valid),
        .upd_dest_id (upd_dest_id),
        .upd_prio    (upd_prio),
        .irq_valid   (irq_valid),
        .irq_target  (irq_target),
        .irq_redir   (irq_redir),
        .irq_vector  (irq_vector),
        .out_valid   (out_valid),
        .out_cpu     (out_cpu),
        .out_vector  (out_vector)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            m_prio[i] = 0;
            m_en[i]   = 1'b0;
        end
    endtask

    task automatic update(input logic [7:0] did, input logic [7:0] prio);
        @(negedge clk);
        upd_valid   = 1'b1;
        upd_dest_id = did;
        upd_prio    = prio;
        @(negedge clk);
        upd_valid = 1'b0;
        if (did[2:0] < 3'd4) begin
            m_prio[did[1:0]] = int'(prio);
            m_en[did[1:0]]   = 1'b1;
        end
    endtask

    function automatic int expect_cpu(input logic [15:0] tgt, input logic redir);
        int best = -1;
        if (redir) begin
            for (int i = 0; i < 4; i++) begin
                if (m_en[i] && (best < 0 || m_prio[i] < m_prio[best])) best = i;
            end
        end
        if (best < 0) best = int'(tgt[1:0]);
        return best;
    endfunction

    task automatic send_irq(input logic [15:0] tgt, input logic redir,
                            input logic [7:0] vec, input int exp_cpu, input string req);
        @(negedge clk);
        irq_valid  = 1'b1;
        irq_target = tgt;
        irq_redir  = redir;
        irq_vector = vec;
        @(negedge clk);
        irq_valid = 1'b0;
        chk({req, " strobe"}, int'(out_valid), 1);
        chk({req, " cpu"}, int'(out_cpu), exp_cpu);
        chk("R8 vector", int'(out_vector), int'(vec));
        @(negedge clk);
        chk("R8 single-cycle strobe", int'(out_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 out_valid after reset", int'(out_valid), 0);
        // R1 / R7: nothing enabled, redirectable goes to addressed target
        for (int t = 0; t < 8; t++) begin
            send_irq(16'(t * 16'h1235), 1'b1, 8'(t + 8'h40),
                     int'(t * 16'h1235) % 4, "R1 R7 none enabled");
        end

        // R3: ignored selectors leave everything disabled
        for (int s = 4; s < 8; s++) update(8'((s << 3) | s), 8'h00);
        send_irq(16'hABC2, 1'b1, 8'h11, 2, "R3 ignored selector");

        // R2: high destination bits ignored, selector 1 written
        update(8'hF9, 8'd30);
        send_irq(16'h0003, 1'b1, 8'h12, 1, "R2 upper did bits");
        update(8'h0B, 8'd20);
        send_irq(16'h0000, 1'b1, 8'h13, 3, "R2 select 3");
        update(8'h0D, 8'd0);
        update(8'h0E, 8'd0);
        send_irq(16'h0000, 1'b1, 8'h14, 3, "R3 ignored after enable");

        // R4: direct delivery ignores registers
        for (int t = 0; t < 16; t++) begin
            send_irq(16'(t * 16'h0F11), 1'b0, 8'(t), int'(t * 16'h0F11) % 4, "R4 direct");
        end

        // R9: update in same cycle as interrupt sees old contents
        do_reset();
        update(8'h02, 8'd5);
        @(negedge clk);
        upd_valid   = 1'b1;
        upd_dest_id = 8'h00;
        upd_prio    = 8'd1;
        irq_valid   = 1'b1;
        irq_target  = 16'h0001;
        irq_redir   = 1'b1;
        irq_vector  = 8'h77;
        @(negedge clk);
        upd_valid = 1'b0;
        irq_valid = 1'b0;
        m_prio[0] = 1;
        m_en[0]   = 1'b1;
        chk("R9 strobe", int'(out_valid), 1);
        chk("R9 old contents", int'(out_cpu), 2);
        send_irq(16'h0001, 1'b1, 8'h78, 0, "R9 new contents");

        // R8: back-to-back requests
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            irq_valid  = 1'b1;
            irq_target = 16'(k + 1);
            irq_redir  = 1'b0;
            irq_vector = 8'(8'hA0 + k);
            @(negedge clk);
            chk("R8 back-to-back strobe", int'(out_valid), 1);
            chk("R8 back-to-back cpu", int'(out_cpu), (k + 1) % 4);
            chk("R8 back-to-back vector", int'(out_vector), 8'hA0 + k);
        end
        irq_valid = 1'b0;
        @(negedge clk);
        chk("R8 strobe ends", int'(out_valid), 0);

        // R5 / R6 / R7: every enable mask, every priority pattern in 0..3
        for (int mask = 1; mask < 16; mask++) begin
            do_reset();
            for (int pat = 0; pat < 256; pat++) begin
                int vals [4];
                int minv;
                int ties;
                int e;
                minv = 256;
                ties = 0;
                for (int i = 0; i < 4; i++) begin
                    vals[i] = (pat >> (2 * i)) & 3;
                    if (mask[i]) update(8'(i), 8'(vals[i]));
                end
                for (int i = 0; i < 4; i++) if (mask[i] && vals[i] < minv) minv = vals[i];
                for (int i = 0; i < 4; i++) if (mask[i] && vals[i] == minv) ties++;
                e = expect_cpu(16'(~mask), 1'b1);
                send_irq(16'(~mask), 1'b1, 8'(pat), e,
                         (ties > 1) ? "R6 tie lowest id" : "R5 R7 lowest enabled");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule